// File: doc/BRIEF.md
# Vector Register Element-Width Tracker

This block records, for every architectural vector register, the element width last written into it and whether the register has been written since reset. A dispatch stage presents one request per cycle. The request carries a valid/ready pair, a flag that says whether it writes a destination, the destination index, the element width, the register-group multiplier code, the segment field count minus one and an operation class. When the request is accepted and writes a destination, every register in its destination span is tagged with the request's width.

A segment memory operation covers more than its base register group. Its span is the group size times the number of fields, starting at the destination index. The span is clipped at the last register and never wraps to register 0. A parameter selects whether segment stores also get the extended span.

Several independent lookup ports read the table for source operands. Each port returns the stored width for its index. It also compares that width with the width the reading instruction wants. A difference raises a mismatch, which tells a later stage to reorder the data layout. A register that was never tagged raises a separate not-written flag and no mismatch.

Top module: `vreg_width_tracker`

## Requirements
- R1: After reset, every register holds width code 0 (8-bit) with its written flag clear. A lookup of any register therefore returns width 0, not-written 1 and mismatch 0.
- R2: The table changes only on a clock edge where `req_valid_i`, `req_ready_i` and `req_wr_dst_i` are all 1. If any of them is 0, every register keeps its width and its written flag.
- R3: The group size comes from `req_grp_i`: 0 gives 1 register, 1 gives 2, 2 gives 4 and 3 gives 8. Every other code (4 to 7, fractional groups) counts as 1 register.
- R4: `req_opc_i` encodes the operation class: 1, 2 and 3 are unit-stride, strided and indexed loads; 4, 5 and 6 are the same three kinds of store; 0 and 7 are other operations. A request is a segment operation when it is a load or a store and `req_nf_i` is nonzero. A segment operation tags group size × (`req_nf_i`+1) registers. Any other request tags only the group size.
- R5: Each tagged register, counted upward from `req_vd_i`, takes the width `req_ew_i` and has its written flag set. Registers outside the span do not change. Example: a 4-field, 16-bit segment load with group size 1 and vd=8 makes registers 8 to 11 read back as width 1.
- R6: Tagging stops at register NREG-1 and never wraps around to register 0.
- R7: A lookup returns the width held before any update that is accepted in the same cycle. The new width becomes visible after that clock edge.
- R8: Width codes are 0=8-bit, 1=16-bit, 2=32-bit and 3=64-bit. Mismatch is 1 exactly when the looked-up register has been written and its stored width differs from the port's requested width. Not-written is 1 exactly when the register's written flag is clear, and mismatch is then 0.
- R9: With the default `SEG_STORE_SPAN`=1, segment stores (classes 4 to 6 with nonzero `req_nf_i`) get the extended span. With 0, stores tag only the group size.
- R10: The NPORT lookup ports (3 by default) work independently. Each port answers for its own index and requested width in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Dispatch request valid |
| req_ready_i | input | 1 | Downstream ready; accepts the request |
| req_wr_dst_i | input | 1 | Request writes a destination register |
| req_vd_i | input | 5 | Destination register index |
| req_ew_i | input | 2 | Element width code of the request |
| req_grp_i | input | 3 | Register-group multiplier code |
| req_nf_i | input | 3 | Segment field count minus one |
| req_opc_i | input | 3 | Operation class code |
| lk_idx_i | input | NPORT*5 | Source register index per port, port p at bits [5p+4:5p] |
| lk_ew_i | input | NPORT*2 | Width requested per port |
| lk_ew_o | output | NPORT*2 | Stored width per port |
| lk_mismatch_o | output | NPORT | Stored and requested widths differ on a written register |
| lk_invalid_o | output | NPORT | Looked-up register has not been written |

## Verification
The lookup outputs are combinational reads of the registered table. A port's result is therefore due in the same cycle its index is applied, and it reflects every update accepted at earlier edges. An accepted update shows up on the ports one rising edge later.

The bench drives each request and lookup just after a falling edge and compares all ports 1 ns later, before the next rising edge. It applies the accepted update to its own model only after that edge. This ordering puts every same-cycle check on the values held before the update. One port always looks at the request's destination, so the moment an update becomes visible is checked in every cycle.

// File: rtl/vwt_pkg.sv
package vwt_pkg;
    localparam int EW_W  = 2;
    localparam int GRP_W = 3;
    localparam int NF_W  = 3;
    localparam int OPC_W = 3;

    typedef enum logic [EW_W-1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } ew_e;

    typedef enum logic [OPC_W-1:0] {
        OPC_OTHER     = 3'd0,
        OPC_LD_UNIT   = 3'd1,
        OPC_LD_STRIDE = 3'd2,
        OPC_LD_INDEX  = 3'd3,
        OPC_ST_UNIT   = 3'd4,
        OPC_ST_STRIDE = 3'd5,
        OPC_ST_INDEX  = 3'd6,
        OPC_ARITH     = 3'd7
    } opc_e;
endpackage

// File: rtl/vwt_span_calc.sv
module vwt_span_calc
    import vwt_pkg::*;
#(
    parameter int NREG           = 32,
    parameter bit SEG_STORE_SPAN = 1'b1,
    localparam int IDX_W = $clog2(NREG),
    localparam int CNT_W = 8
) (
    input  logic [IDX_W-1:0] vd_i,
    input  logic [GRP_W-1:0] grp_i,
    input  logic [NF_W-1:0]  nf_i,
    input  logic [OPC_W-1:0] opc_i,
    output logic [NREG-1:0]  tag_mask_o
);
    logic [3:0]       grp_sz;
    logic [3:0]       fields;
    logic             is_ld;
    logic             is_st;
    logic             is_seg;
    logic [CNT_W-1:0] span;

    // group size from the multiplier code; fractional codes count as one
    always_comb begin
        unique case (grp_i)
            3'd1:    grp_sz = 4'd2;
            3'd2:    grp_sz = 4'd4;
            3'd3:    grp_sz = 4'd8;
            default: grp_sz = 4'd1;
        endcase
    end

    assign is_ld  = (opc_i == OPC_LD_UNIT) || (opc_i == OPC_LD_STRIDE) || (opc_i == OPC_LD_INDEX);
    assign is_st  = (opc_i == OPC_ST_UNIT) || (opc_i == OPC_ST_STRIDE) || (opc_i == OPC_ST_INDEX);
    assign is_seg = (is_ld || (SEG_STORE_SPAN && is_st)) && (nf_i != '0);
    assign fields = is_seg ? ({1'b0, nf_i} + 4'd1) : 4'd1;
    assign span   = {4'b0, grp_sz} * {4'b0, fields};

    // one compare per register; the span is clipped at the top, no wrap
    for (genvar g = 0; g < NREG; g++) begin : g_mask
        assign tag_mask_o[g] = (g >= int'(vd_i)) && ((g - int'(vd_i)) < int'(span));
    end
endmodule

// File: rtl/vwt_lookup_port.sv
module vwt_lookup_port
    import vwt_pkg::*;
#(
    parameter int NREG = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0][EW_W-1:0] tbl_w_i,
    input  logic [NREG-1:0]           tbl_v_i,
    input  logic [IDX_W-1:0]          idx_i,
    input  logic [EW_W-1:0]           want_ew_i,
    output logic [EW_W-1:0]           held_ew_o,
    output logic                      mismatch_o,
    output logic                      invalid_o
);
    logic written;

    assign held_ew_o  = tbl_w_i[idx_i];
    assign written    = tbl_v_i[idx_i];
    assign mismatch_o = written && (held_ew_o != want_ew_i);
    assign invalid_o  = !written;
endmodule

// File: rtl/vreg_width_tracker.sv
module vreg_width_tracker
    import vwt_pkg::*;
#(
    parameter int NREG           = 32,
    parameter int NPORT          = 3,
    parameter bit SEG_STORE_SPAN = 1'b1,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    req_valid_i,
    input  logic                    req_ready_i,
    input  logic                    req_wr_dst_i,
    input  logic [IDX_W-1:0]        req_vd_i,
    input  logic [EW_W-1:0]         req_ew_i,
    input  logic [GRP_W-1:0]        req_grp_i,
    input  logic [NF_W-1:0]         req_nf_i,
    input  logic [OPC_W-1:0]        req_opc_i,
    input  logic [NPORT*IDX_W-1:0]  lk_idx_i,
    input  logic [NPORT*EW_W-1:0]   lk_ew_i,
    output logic [NPORT*EW_W-1:0]   lk_ew_o,
    output logic [NPORT-1:0]        lk_mismatch_o,
    output logic [NPORT-1:0]        lk_invalid_o
);
    typedef struct packed {
        logic [NREG-1:0][EW_W-1:0] w;
        logic [NREG-1:0]           v;
    } state_t;

    state_t st_d, st_q;
    logic [NREG-1:0]           tag_mask;
    logic                      upd;
    logic [NREG-1:0][EW_W-1:0] tbl_w;
    logic [NREG-1:0]           tbl_v;

    vwt_span_calc #(
        .NREG           (NREG),
        .SEG_STORE_SPAN (SEG_STORE_SPAN)
    ) i_span (
        .vd_i       (req_vd_i),
        .grp_i      (req_grp_i),
        .nf_i       (req_nf_i),
        .opc_i      (req_opc_i),
        .tag_mask_o (tag_mask)
    );

    assign upd = req_valid_i && req_ready_i && req_wr_dst_i;

    always_comb begin
        st_d = st_q;
        if (upd) begin
            for (int r = 0; r < NREG; r++) begin
                if (tag_mask[r]) begin
                    st_d.w[r] = req_ew_i;
                    st_d.v[r] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tbl_w = st_q.w;
    assign tbl_v = st_q.v;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        vwt_lookup_port #(
            .NREG (NREG)
        ) i_lk (
            .tbl_w_i    (tbl_w),
            .tbl_v_i    (tbl_v),
            .idx_i      (lk_idx_i[p*IDX_W +: IDX_W]),
            .want_ew_i  (lk_ew_i[p*EW_W +: EW_W]),
            .held_ew_o  (lk_ew_o[p*EW_W +: EW_W]),
            .mismatch_o (lk_mismatch_o[p]),
            .invalid_o  (lk_invalid_o[p])
        );
    end
endmodule

// File: rtl/vwt_checker.sv
module vwt_checker
    import vwt_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int NPORT = 3,
    localparam int IDX_W = $clog2(NREG)
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic                      req_valid_i,
    input logic                      req_ready_i,
    input logic                      req_wr_dst_i,
    input logic [IDX_W-1:0]          req_vd_i,
    input logic [EW_W-1:0]           req_ew_i,
    input logic [NREG-1:0][EW_W-1:0] tbl_w_i,
    input logic [NREG-1:0]           tbl_v_i,
    input logic [NPORT*EW_W-1:0]     lk_ew_i,
    input logic [NPORT*EW_W-1:0]     lk_ew_o,
    input logic [NPORT-1:0]          lk_mismatch_o,
    input logic [NPORT-1:0]          lk_invalid_o
);
    logic acc;
    assign acc = req_valid_i && req_ready_i && req_wr_dst_i;

    // R2: with no accepted write, the table holds
    p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !acc |=> ($stable(tbl_w_i) && $stable(tbl_v_i)));

    // R5: the base register always takes the request width
    p_base_tag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc |=> (tbl_w_i[$past(req_vd_i)] == $past(req_ew_i)) && tbl_v_i[$past(req_vd_i)]);

    // R6: a write starting at the top register leaves register 0 alone
    p_no_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc && (req_vd_i == IDX_W'(NREG-1))) |=>
            ((tbl_w_i[0] == $past(tbl_w_i[0])) && (tbl_v_i[0] == $past(tbl_v_i[0]))));

    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        // R8: mismatch and not-written never together
        p_flags_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $onehot0({lk_mismatch_o[p], lk_invalid_o[p]}));
        // R8: a mismatch means the returned width differs from the wanted one
        p_mismatch_diff_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            lk_mismatch_o[p] |-> (lk_ew_o[p*EW_W +: EW_W] != lk_ew_i[p*EW_W +: EW_W]));
        // R1: an unwritten register still reads the reset width
        p_unwritten_ew8_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            lk_invalid_o[p] |-> (lk_ew_o[p*EW_W +: EW_W] == EW_8));
    end
endmodule

bind vreg_width_tracker vwt_checker #(
    .NREG  (NREG),
    .NPORT (NPORT)
) u_vwt_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_ready_i   (req_ready_i),
    .req_wr_dst_i  (req_wr_dst_i),
    .req_vd_i      (req_vd_i),
    .req_ew_i      (req_ew_i),
    .tbl_w_i       (tbl_w),
    .tbl_v_i       (tbl_v),
    .lk_ew_i       (lk_ew_i),
    .lk_ew_o       (lk_ew_o),
    .lk_mismatch_o (lk_mismatch_o),
    .lk_invalid_o  (lk_invalid_o)
);

// File: tb/test_vreg_width_tracker.sv
`timescale 1ns/1ps
module test_vreg_width_tracker;
    localparam int NREG  = 32;
    localparam int NPORT = 3;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  req_valid = 1'b0;
    logic                  req_ready = 1'b0;
    logic                  req_wr = 1'b0;
    logic [4:0]            req_vd = '0;
    logic [1:0]            req_ew = '0;
    logic [2:0]            req_grp = '0;
    logic [2:0]            req_nf = '0;
    logic [2:0]            req_opc = '0;
    logic [NPORT*5-1:0]    lk_idx = '0;
    logic [NPORT*2-1:0]    lk_ew = '0;
    logic [NPORT*2-1:0]    lk_ew_o;
    logic [NPORT-1:0]      lk_mm;
    logic [NPORT-1:0]      lk_inv;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    logic [1:0] m_w [NREG];
    bit         m_v [NREG];

    always #5 clk = ~clk;

    vreg_width_tracker i_vreg_width_tracker (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_ready_i(req_ready), .req_wr_dst_i(req_wr),
        .req_vd_i(req_vd), .req_ew_i(req_ew), .req_grp_i(req_grp),
        .req_nf_i(req_nf), .req_opc_i(req_opc),
        .lk_idx_i(lk_idx), .lk_ew_i(lk_ew),
        .lk_ew_o(lk_ew_o), .lk_mismatch_o(lk_mm), .lk_invalid_o(lk_inv)
    );

    // R3, R4, R9 expected span length
    function automatic int exp_span(logic [2:0] grp, logic [2:0] nf, logic [2:0] opc);
        int g;
        bit seg;
        case (grp)
            3'd1: g = 2;
            3'd2: g = 4;
            3'd3: g = 8;
            default: g = 1;
        endcase
        seg = (opc >= 3'd1) && (opc <= 3'd6) && (nf != 0);
        return seg ? g * (int'(nf) + 1) : g;
    endfunction

    task automatic model_reset();
        for (int r = 0; r < NREG; r++) begin
            m_w[r] = 2'd0;
            m_v[r] = 1'b0;
        end
    endtask

    task automatic check_port(int p, string tag);
        int idx;
        logic [1:0] want, e_ew, a_ew;
        bit e_mm, e_inv;
        idx   = int'(lk_idx[p*5 +: 5]);
        want  = lk_ew[p*2 +: 2];
        e_ew  = m_w[idx];
        e_inv = !m_v[idx];
        e_mm  = m_v[idx] && (m_w[idx] != want);
        a_ew  = lk_ew_o[p*2 +: 2];
        vectors++;
        if (a_ew !== e_ew || lk_mm[p] !== e_mm || lk_inv[p] !== e_inv) begin
            misses++;
            $display("FAIL %s port%0d reg%0d: got ew=%0d mm=%0b inv=%0b, expected ew=%0d mm=%0b inv=%0b",
                     tag, p, idx, a_ew, lk_mm[p], lk_inv[p], e_ew, e_mm, e_inv);
        end
    endtask

    // one cycle: drive after falling edge, check pre-edge (R7), then model the edge
    task automatic do_cycle(bit v, bit rdy, bit wr, int vd, int ew, int grp, int nf, int opc,
                            bit rnd_lk, string tag);
        int cnt;
        @(negedge clk);
        req_valid = v; req_ready = rdy; req_wr = wr;
        req_vd = 5'(vd); req_ew = 2'(ew); req_grp = 3'(grp); req_nf = 3'(nf); req_opc = 3'(opc);
        lk_idx[4:0] = 5'(vd);
        lk_ew[1:0]  = 2'(ew);
        for (int p = 1; p < NPORT; p++) begin
            lk_idx[p*5 +: 5] = rnd_lk ? 5'($urandom_range(0, NREG-1)) : 5'((vd + p) % NREG);
            lk_ew[p*2 +: 2]  = 2'($urandom_range(0, 3));
        end
        #1;
        for (int p = 0; p < NPORT; p++) check_port(p, tag);
        @(posedge clk);
        if (v && rdy && wr) begin
            cnt = exp_span(3'(grp), 3'(nf), 3'(opc));
            for (int r = vd; r < NREG && r < vd + cnt; r++) begin
                m_w[r] = 2'(ew);
                m_v[r] = 1'b1;
            end
        end
    endtask

    // read the whole table through all ports, idle request (R10)
    task automatic sweep(string tag);
        for (int b = 0; b < NREG; b += NPORT) begin
            @(negedge clk);
            req_valid = 1'b0;
            for (int p = 0; p < NPORT; p++) begin
                lk_idx[p*5 +: 5] = 5'((b + p) % NREG);
                lk_ew[p*2 +: 2]  = 2'((b + 2*p) % 4);
            end
            #1;
            for (int p = 0; p < NPORT; p++) check_port(p, tag);
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state everywhere
        sweep("R1");
        // R2: not accepted, three ways
        do_cycle(1, 0, 1, 4, 2, 0, 0, 7, 0, "R2");
        do_cycle(0, 1, 1, 4, 2, 0, 0, 7, 0, "R2");
        do_cycle(1, 1, 0, 4, 2, 0, 0, 7, 0, "R2");
        sweep("R2");
        // R4, R5, R7: 4-field 16-bit segment load at vd=8
        do_cycle(1, 1, 1, 8, 1, 0, 3, 1, 0, "R7");
        do_cycle(0, 0, 0, 8, 1, 0, 0, 0, 0, "R5");
        sweep("R5");
        // R4: nf set but non-memory op tags only the group
        do_cycle(1, 1, 1, 16, 2, 1, 2, 7, 0, "R4");
        sweep("R4");
        // R3: fractional group code counts as one register
        do_cycle(1, 1, 1, 20, 3, 5, 0, 0, 0, "R3");
        do_cycle(1, 1, 1, 24, 3, 2, 0, 0, 0, "R3");
        sweep("R3");
        // R9: segment store gets the span by default
        do_cycle(1, 1, 1, 2, 3, 0, 1, 5, 0, "R9");
        sweep("R9");
        // R6: clip at top, no wrap
        do_cycle(1, 1, 1, 30, 2, 2, 0, 0, 0, "R6");
        do_cycle(1, 1, 1, 31, 1, 3, 7, 3, 0, "R6");
        sweep("R6");
        // R8: mismatch on written registers at a different width
        do_cycle(1, 1, 1, 0, 3, 3, 7, 2, 0, "R8");
        sweep("R8");
        // reset again, then random traffic
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        sweep("R1");
        for (int i = 0; i < 400; i++) begin
            do_cycle(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     $urandom_range(0, NREG-1), $urandom_range(0, 3), $urandom_range(0, 7),
                     $urandom_range(0, 7), $urandom_range(0, 7), 1, "R8");
        end
        sweep("R10");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule